// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Branch Comparator

This block is the combinational execute datapath for a 32-bit base integer pipeline. It takes two operands and a three-bit function code with a modifier bit, and returns a result word. The same datapath serves register-register and register-immediate forms. A second three-bit code selects one of six conditional-branch comparisons of the same two operands. A single shared magnitude comparator drives both the set-less-than result and the branch-taken flag.

There is no clock and no state. The surrounding pipeline decodes the instruction word and presents the function fields, the operands and, for branches, the branch code. The block does no register-file access, no memory access and no multiply or divide.

Top module: `rv32_int_alu`

## Requirements
- R1: With `fn_sel`=000 and either `fn_alt`=0 or `fn_imm`=1, `result` is the sum of `opnd_a` and `opnd_b`, truncated to 32 bits. The immediate form always adds.
- R2: With `fn_sel`=000, `fn_alt`=1 and `fn_imm`=0, `result` is `opnd_a` minus `opnd_b`, truncated to 32 bits.
- R3: With `fn_sel`=010, `result` is 1 when `opnd_a` is less than `opnd_b` as two's-complement signed numbers, and 0 otherwise.
- R4: With `fn_sel`=011, `result` is 1 when `opnd_a` is less than `opnd_b` as unsigned numbers, and 0 otherwise. A zero A against a nonzero B gives 1; two zero operands give 0.
- R5: With `fn_sel`=001, `result` is `opnd_a` shifted left, filling with zeros. The shift distance is only `opnd_b[4:0]`; the higher bits of B have no effect.
- R6: With `fn_sel`=101, `result` is `opnd_a` shifted right by `opnd_b[4:0]`. `fn_alt`=0 fills with zeros. `fn_alt`=1 copies the sign bit into the vacated upper bits. This holds in both the register and the immediate form.
- R7: `fn_sel`=111 gives bitwise AND, 110 gives OR and 100 gives XOR. XOR against an all-ones B yields the inversion of A.
- R8: `br_taken` is 1 for `br_sel`=000 when the operands are equal, and for 001 when they differ.
- R9: `br_taken` is 1 for `br_sel`=100 when A is signed-less than B, and for 101 when A is signed-greater-or-equal to B.
- R10: `br_taken` is 1 for `br_sel`=110 when A is unsigned-less than B, and for 111 when A is unsigned-greater-or-equal to B.
- R11: `br_sel` codes 010 and 011 hold `br_taken` at 0 for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fn_sel | input | 3 | Arithmetic/logic function code |
| fn_alt | input | 1 | Modifier: subtract, or arithmetic right shift |
| fn_imm | input | 1 | Operand B came from an immediate |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand or immediate |
| br_sel | input | 3 | Branch condition code |
| result | output | 32 | Function result |
| br_taken | output | 1 | Branch condition holds |

## Verification
The result word and the branch flag are produced from the same operands in the same evaluation, through one comparator. Every vector therefore drives a random function code and a random branch code at once, so a set-less-than and a branch compare often read the comparator together. Both outputs are judged in that same cycle against an independent reference model. Directed vectors pair a signed compare with an unsigned one on operands of opposite sign, where the two answers must differ.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
      OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
   } alu_op_e;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_pkg::*;
(
   input  logic [2:0] fn_sel,
   input  logic       fn_alt,
   input  logic       fn_imm,
   output alu_op_e    op
);
   always_comb begin
      unique case (fn_sel)
         3'b000:  op = (fn_alt && !fn_imm) ? OP_SUB : OP_ADD;
         3'b001:  op = OP_SLL;
         3'b010:  op = OP_SLT;
         3'b011:  op = OP_SLTU;
         3'b100:  op = OP_XOR;
         3'b101:  op = fn_alt ? OP_SRA : OP_SRL;
         3'b110:  op = OP_OR;
         default: op = OP_AND;
      endcase
   end

   always_comb begin
      if (fn_imm && fn_sel == 3'b000)
         AST_IMM_NEVER_SUB: assert (op == OP_ADD); // R1
   end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            eq,
   output logic            lt_s,
   output logic            lt_u
);
   localparam int MSB = XLEN - 1;

   logic [XLEN:0] diff_ext;

   always_comb begin
      diff_ext = {1'b0, a} - {1'b0, b};
      eq       = (a == b);
      lt_u     = diff_ext[XLEN];
      lt_s     = (a[MSB] ^ b[MSB]) ? a[MSB] : lt_u;
   end

   always_comb begin
      if (eq)
         AST_EQ_EXCLUDES_LT: assert (!lt_s && !lt_u); // R9
   end

   always_comb begin
      if (a[MSB] != b[MSB])
         AST_SIGN_SPLIT: assert (lt_s == !lt_u); // R3
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int XLEN    = 32,
   parameter int SHAMT_W = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]    data,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic               to_left,
   input  logic               arith,
   output logic [XLEN-1:0]    out
);
   logic [XLEN-1:0] rev_in;
   logic [XLEN-1:0] rev_out;
   logic [XLEN-1:0] stg [0:SHAMT_W];
   logic            fill;

   for (genvar i = 0; i < XLEN; i++) begin : g_rev
      assign rev_in[i]  = data[XLEN-1-i];
      assign rev_out[i] = stg[SHAMT_W][XLEN-1-i];
   end

   assign fill   = arith & ~to_left & data[XLEN-1];
   assign stg[0] = to_left ? rev_in : data;

   for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stg[s+1] = shamt[s] ? {{STEP{fill}}, stg[s][XLEN-1:STEP]} : stg[s];
   end

   assign out = to_left ? rev_out : stg[SHAMT_W];

   always_comb begin
      if (shamt == '0)
         AST_ZERO_SHIFT_PASSES: assert (out == data); // R5
   end

   always_comb begin
      if (!to_left && !fill && shamt != '0)
         AST_RIGHT_TOP_CLEAR: assert (out[XLEN-1] == 1'b0); // R6
   end
endmodule

// File: rtl/alu_branch.sv
module alu_branch (
   input  logic [2:0] br_sel,
   input  logic       eq,
   input  logic       lt_s,
   input  logic       lt_u,
   output logic       taken
);
   always_comb begin
      unique case (br_sel)
         3'b000:  taken = eq;
         3'b001:  taken = ~eq;
         3'b100:  taken = lt_s;
         3'b101:  taken = ~lt_s;
         3'b110:  taken = lt_u;
         3'b111:  taken = ~lt_u;
         default: taken = 1'b0;
      endcase
   end

   always_comb begin
      if (eq && br_sel[2])
         AST_EQ_MEANS_GE: assert (taken == br_sel[0]); // R10
   end
endmodule

// File: rtl/rv32_int_alu.sv
module rv32_int_alu
   import alu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [2:0]      fn_sel,
   input  logic            fn_alt,
   input  logic            fn_imm,
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   input  logic [2:0]      br_sel,
   output logic [XLEN-1:0] result,
   output logic            br_taken
);
   localparam int SHAMT_W = $clog2(XLEN);

   if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_width
      $error("rv32_int_alu: XLEN must be a power of two of at least 8");
   end

   alu_op_e         op;
   logic            eq, lt_s, lt_u;
   logic            is_sub;
   logic [XLEN-1:0] addend;
   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] shifted;

   alu_decode u_decode (
      .fn_sel (fn_sel),
      .fn_alt (fn_alt),
      .fn_imm (fn_imm),
      .op     (op)
   );

   alu_compare #(.XLEN(XLEN)) u_compare (
      .a    (opnd_a),
      .b    (opnd_b),
      .eq   (eq),
      .lt_s (lt_s),
      .lt_u (lt_u)
   );

   alu_shifter #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_shifter (
      .data    (opnd_a),
      .shamt   (opnd_b[SHAMT_W-1:0]),
      .to_left (op == OP_SLL),
      .arith   (op == OP_SRA),
      .out     (shifted)
   );

   alu_branch u_branch (
      .br_sel (br_sel),
      .eq     (eq),
      .lt_s   (lt_s),
      .lt_u   (lt_u),
      .taken  (br_taken)
   );

   assign is_sub = (op == OP_SUB);
   assign addend = is_sub ? ~opnd_b : opnd_b;
   assign sum    = opnd_a + addend + {{(XLEN-1){1'b0}}, is_sub};

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB:  result = sum;
         OP_SLT:          result = {{(XLEN-1){1'b0}}, lt_s};
         OP_SLTU:         result = {{(XLEN-1){1'b0}}, lt_u};
         OP_SLL, OP_SRL,
         OP_SRA:          result = shifted;
         OP_XOR:          result = opnd_a ^ opnd_b;
         OP_OR:           result = opnd_a | opnd_b;
         default:         result = opnd_a & opnd_b;
      endcase
   end

   always_comb begin
      if (fn_sel == 3'b010 && br_sel == 3'b100)
         AST_SLT_MATCHES_BLT: assert (result[0] == br_taken); // R3
   end

   always_comb begin
      if (fn_sel == 3'b100 && opnd_b == '1)
         AST_XOR_INVERTS: assert (result == ~opnd_a); // R7
   end

   always_comb begin
      if (br_sel == 3'b010 || br_sel == 3'b011)
         AST_UNUSED_BRANCH_LOW: assert (!br_taken); // R11
   end
endmodule

// File: tb/rv32_int_alu_tb.sv
module rv32_int_alu_tb;
   logic        clk = 1'b0;
   logic [2:0]  fn_sel = '0;
   logic        fn_alt = 1'b0;
   logic        fn_imm = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [2:0]  br_sel = '0;
   logic [31:0] result;
   logic        br_taken;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [31:0] res;
      logic        br;
      string       tag_res;
      string       tag_br;
   } exp_t;

   exp_t exp_q[$];
   exp_t cur;

   always #5 clk = ~clk;

   rv32_int_alu u_dut (
      .fn_sel   (fn_sel),
      .fn_alt   (fn_alt),
      .fn_imm   (fn_imm),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .br_sel   (br_sel),
      .result   (result),
      .br_taken (br_taken)
   );

   function automatic logic [31:0] ref_res(logic [2:0] f, logic alt, logic imm,
                                           logic [31:0] a, logic [31:0] b);
      case (f)
         3'b000:  return (alt && !imm) ? a - b : a + b;
         3'b001:  return a << b[4:0];
         3'b010:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         3'b011:  return (a < b) ? 32'd1 : 32'd0;
         3'b100:  return a ^ b;
         3'b101:  return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
         3'b110:  return a | b;
         default: return a & b;
      endcase
   endfunction

   function automatic logic ref_br(logic [2:0] c, logic [31:0] a, logic [31:0] b);
      case (c)
         3'b000:  return a == b;
         3'b001:  return a != b;
         3'b100:  return $signed(a) < $signed(b);
         3'b101:  return $signed(a) >= $signed(b);
         3'b110:  return a < b;
         3'b111:  return a >= b;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string tag_of_fn(logic [2:0] f, logic alt, logic imm);
      case (f)
         3'b000:  return (alt && !imm) ? "R2" : "R1";
         3'b001:  return "R5";
         3'b010:  return "R3";
         3'b011:  return "R4";
         3'b101:  return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic string tag_of_br(logic [2:0] c);
      case (c)
         3'b000, 3'b001: return "R8";
         3'b100, 3'b101: return "R9";
         3'b110, 3'b111: return "R10";
         default:        return "R11";
      endcase
   endfunction

   task automatic drive(input logic [2:0] f, input logic alt, input logic imm,
                        input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
      exp_t e;
      @(negedge clk);
      fn_sel = f; fn_alt = alt; fn_imm = imm;
      opnd_a = a; opnd_b = b; br_sel = c;
      e.res     = ref_res(f, alt, imm, a, b);
      e.br      = ref_br(c, a, b);
      e.tag_res = tag_of_fn(f, alt, imm);
      e.tag_br  = tag_of_br(c);
      exp_q.push_back(e);
   endtask

   always @(posedge clk) begin
      if (exp_q.size() != 0) begin
         cur = exp_q.pop_front();
         checks++;
         if (result !== cur.res) begin
            errors++;
            $display("FAIL %s result: actual=%h expected=%h", cur.tag_res, result, cur.res);
         end
         checks++;
         if (br_taken !== cur.br) begin
            errors++;
            $display("FAIL %s br_taken: actual=%b expected=%b", cur.tag_br, br_taken, cur.br);
         end
      end
   end

   function automatic logic [31:0] pick_operand();
      case ($urandom_range(0, 5))
         0:       return 32'h0000_0000;
         1:       return 32'hFFFF_FFFF;
         2:       return 32'h8000_0000;
         3:       return 32'h7FFF_FFFF;
         default: return $urandom();
      endcase
   endfunction

   initial begin
      // idle inputs: R1 add of zeros, R8 equal operands
      drive(3'b000, 1'b0, 1'b0, 32'h0, 32'h0, 3'b000);
      // R1 wraparound and the immediate form ignoring the modifier
      drive(3'b000, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1, 3'b001);
      drive(3'b000, 1'b1, 1'b1, 32'h7FFF_FFFF, 32'h1, 3'b000);
      // R2 subtract to negative
      drive(3'b000, 1'b1, 1'b0, 32'h1, 32'h2, 3'b100);
      // R3 signed and R4 unsigned on opposite-sign operands
      drive(3'b010, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1, 3'b110);
      drive(3'b011, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h1, 3'b101);
      drive(3'b011, 1'b0, 1'b1, 32'h0, 32'h5, 3'b111);
      drive(3'b011, 1'b0, 1'b1, 32'h0, 32'h0, 3'b111);
      // R5 upper bits of the distance ignored
      drive(3'b001, 1'b0, 1'b0, 32'h0000_0003, 32'hFFFF_FFE1, 3'b000);
      // R6 logical and arithmetic right shifts
      drive(3'b101, 1'b0, 1'b0, 32'h8000_0000, 32'd31, 3'b001);
      drive(3'b101, 1'b1, 1'b1, 32'h8000_0000, 32'd31, 3'b100);
      drive(3'b101, 1'b1, 1'b0, 32'h4000_0000, 32'd4, 3'b101);
      // R7 logic, XOR inversion
      drive(3'b100, 1'b0, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF, 3'b110);
      drive(3'b110, 1'b0, 1'b0, 32'h2, 32'h5, 3'b111);
      drive(3'b111, 1'b0, 1'b0, 32'h1, 32'h3, 3'b000);
      // R11 unused codes with equal and unequal operands
      drive(3'b000, 1'b0, 1'b0, 32'h9, 32'h9, 3'b010);
      drive(3'b000, 1'b0, 1'b0, 32'h0, 32'h9, 3'b011);
      // mixed random traffic: function and branch evaluated together
      for (int i = 0; i < 800; i++) begin
         drive(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               pick_operand(), pick_operand(), 3'($urandom_range(0, 7)));
      end
      @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule